// File: doc/BRIEF.md
# Comma-Aligned Serial-to-Parallel Word Assembler

This block sits behind a clock-and-data recovery stage. Each cycle in which a bit-valid strobe is high, it takes one retimed serial bit from either the line input or the loopback input and packs the bits into parallel words. A word is 20 bits wide, or 10 bits wide in narrow mode. A single-cycle word-valid pulse marks each new word. The parallel bus and the sync flag then hold their values until the next word is presented.

When framing is enabled, the block watches a sliding ten-bit window for the positive-disparity K28.5 comma. It moves the word boundary so that the comma opens a new word. The bits of the word that was in progress are dropped, so the time between two words can grow but never shrink. Words are presented ten accepted bits after their last bit arrives. This lookahead lets the boundary move before any part of the comma has been packed. A sync flag marks every word whose leading character is the comma. When framing is disabled, the block cuts the stream into fixed-size chunks and does no alignment.

Top module: `dsz_comma_deser`

## Requirements
- R1: During and directly after synchronous reset, `par_data` is all ones and both `word_vld` and `sync_flag` are 0.
- R2: When `loop_sel` is 1, serial bits come from `ser_loop` and `ser_main` has no effect. When `loop_sel` is 0, the roles of the two inputs swap.
- R3: With `narrow`=0, each word holds 20 bits, and lane k carries the k-th received bit of the word. `word_vld` is high in the cycle after the acceptance of the tenth bit that follows the word's last bit.
- R4: With `narrow`=1, each word holds 10 bits. Lane 10+k carries the k-th received bit, and lanes 0 to 9 read 1.
- R5: With `frame_en`=1, a comma is the ten bits 0,0,1,1,1,1,1,0,1,0 in reception order. A comma that starts at bit s makes s the first bit of a word, and the unfinished bits before s are dropped. Two words are never less than one word length of accepted bits apart.
- R6: `sync_flag` is updated with each word. It is 1 exactly when the word's first ten received bits (lanes 0 to 9 when wide, lanes 10 to 19 when narrow) form the comma, and it holds with the data until the next word.
- R7: With `frame_en`=0, words are consecutive chunks of one word length, counted from the first bit after reset or after a restart. The block does no alignment.
- R8: A falling edge on `frame_en` drops the unfinished word. The next word starts with the next bit that leaves the lookahead.
- R9: A rising edge on `narrow` resets the word counter in the same way as R8.
- R10: In a cycle with `bit_vld`=0, no bit is accepted and the outputs keep their values.
- R11: `word_vld` is never high in two cycles in a row. `par_data` and `sync_flag` change only in cycles with `word_vld` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_main | input | 1 | Line serial bit |
| ser_loop | input | 1 | Loopback serial bit |
| loop_sel | input | 1 | 1 selects the loopback input |
| bit_vld | input | 1 | Serial bit valid in this cycle |
| frame_en | input | 1 | 1 enables comma alignment |
| narrow | input | 1 | 1 selects 10-bit words, 0 selects 20-bit words |
| par_data | output | 20 | Parallel word; lane 0 is received first when wide, lane 10 when narrow |
| word_vld | output | 1 | One-cycle strobe for a new word |
| sync_flag | output | 1 | Current word leads with the comma |

## Verification
In both widths, the comma is swept through every bit offset inside a word, behind pseudo-random filler. This shows whether the boundary really moves to the comma or only matches it when it is already aligned. The same sweeps are repeated with framing off, to show that the data is cut into fixed chunks and that the sync flag follows only the word content. Further runs use the loopback input with random gaps in the bit strobe, and drive garbage on the unselected input. Two more runs turn framing off or switch to narrow mode partway through a stream, to check that the counter restarts at the correct bit.

// File: rtl/dsz_pkg.sv
// Shared constants for the comma-aligned word assembler.
// Assumes a ten-bit transmission character.
package dsz_pkg;
    localparam int CHAR_W = 10;

    // Comma in reception order: bit CHAR_W-1 is the first received.
    localparam logic [CHAR_W-1:0] COMMA_RX = 10'b0011111010;

    // Reorders a reception-order character into lane order (lane 0 first received).
    function automatic logic [CHAR_W-1:0] to_lanes(input logic [CHAR_W-1:0] v);
        logic [CHAR_W-1:0] r;
        for (int i = 0; i < CHAR_W; i++) r[i] = v[CHAR_W-1-i];
        return r;
    endfunction
endpackage

// File: rtl/dsz_comma_window.sv
// Ten-bit sliding window over accepted serial bits.
// Flags a comma on the bit that completes it, and releases each bit
// again once it has left the window (a ten-bit lookahead delay).
// Assumes bit_vld qualifies bit_in; reset empties the window.
module dsz_comma_window #(
    parameter int CHAR_W = dsz_pkg::CHAR_W
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_in,
    input  logic bit_vld,
    output logic dly_bit,
    output logic dly_vld,
    output logic comma_hit
);
    localparam int FILL_W = $clog2(CHAR_W + 1);
    localparam logic [FILL_W-1:0] FULL = FILL_W'(CHAR_W);

    logic [CHAR_W-1:0] hist;
    logic [FILL_W-1:0] fill;
    logic [CHAR_W-1:0] win;

    // Window as it stands once the incoming bit is included.
    assign win       = {hist[CHAR_W-2:0], bit_in};
    assign comma_hit = bit_vld && (fill >= FULL - 1'b1) && (win == dsz_pkg::COMMA_RX);
    assign dly_vld   = bit_vld && (fill == FULL);
    assign dly_bit   = hist[CHAR_W-1];

    // Shift accepted bits in and count until the window is full.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist <= '1;
            fill <= '0;
        end else if (bit_vld) begin
            hist <= win;
            if (fill != FULL) fill <= fill + 1'b1;
        end
    end

    assert_fill_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= FULL);
    assert_lookahead_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
        dly_vld |-> $past(fill) >= FULL - 1'b1);
endmodule

// File: rtl/dsz_word_builder.sv
// Packs lookahead-delayed bits into 10- or 20-bit words and places them
// on the lanes. Resets its counter on a realign request (comma ahead) or
// on a restart request. Assumes narrow changes only while dly_vld is low.
module dsz_word_builder #(
    parameter int CHAR_W = dsz_pkg::CHAR_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  dly_bit,
    input  logic                  dly_vld,
    input  logic                  realign,
    input  logic                  restart,
    input  logic                  narrow,
    output logic [2*CHAR_W-1:0]   par_data,
    output logic                  word_vld,
    output logic                  sync_flag
);
    localparam int WIDE_W = 2 * CHAR_W;
    localparam int CNT_W  = $clog2(WIDE_W);
    localparam logic [CHAR_W-1:0] COMMA_LANES = dsz_pkg::to_lanes(dsz_pkg::COMMA_RX);

    logic [CNT_W-1:0]  cnt;
    logic [CNT_W-1:0]  last_idx;
    logic [CNT_W-1:0]  pos;
    logic [WIDE_W-1:0] acc;
    logic [WIDE_W-1:0] acc_n;
    logic [WIDE_W-1:0] word_n;
    logic [CHAR_W-1:0] head;
    logic              done;

    // Slot of the incoming bit, and whether it closes the word.
    always_comb begin
        last_idx = narrow ? CNT_W'(CHAR_W - 1) : CNT_W'(WIDE_W - 1);
        pos      = narrow ? CNT_W'(CHAR_W) + cnt : cnt;
        acc_n    = acc;
        if (dly_vld) acc_n[pos] = dly_bit;
        done     = dly_vld && (cnt == last_idx) && !restart;
        head     = narrow ? acc_n[WIDE_W-1:CHAR_W] : acc_n[CHAR_W-1:0];
    end

    // Lane placement: in narrow mode the low lanes read high.
    for (genvar i = 0; i < WIDE_W; i++) begin : g_lane
        if (i < CHAR_W) begin : g_lo
            assign word_n[i] = narrow | acc_n[i];
        end else begin : g_hi
            assign word_n[i] = acc_n[i];
        end
    end

    // Counter, accumulator and output word registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt       <= '0;
            acc       <= '0;
            par_data  <= '1;
            word_vld  <= 1'b0;
            sync_flag <= 1'b0;
        end else begin
            acc      <= acc_n;
            word_vld <= done;
            if (done) begin
                par_data  <= word_n;
                sync_flag <= (head == COMMA_LANES);
            end
            if (restart || realign || done) cnt <= '0;
            else if (dly_vld)               cnt <= cnt + 1'b1;
        end
    end

    assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < CNT_W'(WIDE_W));
    assert_single_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        word_vld |=> !word_vld);
    assert_hold_between_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !word_vld |-> ($stable(par_data) && $stable(sync_flag)));
    assert_low_lanes_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (word_vld && $past(narrow)) |-> (par_data[CHAR_W-1:0] == '1));
endmodule

// File: rtl/dsz_comma_deser.sv
// Top level: serial input select, edge detection on the mode inputs,
// comma lookahead window and word builder.
// Assumes frame_en and narrow change only in cycles with bit_vld low.
module dsz_comma_deser #(
    parameter int CHAR_W = dsz_pkg::CHAR_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ser_main,
    input  logic                ser_loop,
    input  logic                loop_sel,
    input  logic                bit_vld,
    input  logic                frame_en,
    input  logic                narrow,
    output logic [2*CHAR_W-1:0] par_data,
    output logic                word_vld,
    output logic                sync_flag
);
    logic ser_bit;
    logic narrow_q;
    logic frame_q;
    logic restart;
    logic dly_bit;
    logic dly_vld;
    logic comma_hit;

    assign ser_bit = loop_sel ? ser_loop : ser_main;
    assign restart = (narrow && !narrow_q) || (frame_q && !frame_en);

    // Previous mode levels; loaded with the live levels during reset.
    always_ff @(posedge clk) begin
        narrow_q <= narrow;
        frame_q  <= frame_en;
    end

    dsz_comma_window #(.CHAR_W(CHAR_W)) u_window (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_in    (ser_bit),
        .bit_vld   (bit_vld),
        .dly_bit   (dly_bit),
        .dly_vld   (dly_vld),
        .comma_hit (comma_hit)
    );

    dsz_word_builder #(.CHAR_W(CHAR_W)) u_builder (
        .clk       (clk),
        .rst_n     (rst_n),
        .dly_bit   (dly_bit),
        .dly_vld   (dly_vld),
        .realign   (comma_hit && frame_en),
        .restart   (restart),
        .narrow    (narrow),
        .par_data  (par_data),
        .word_vld  (word_vld),
        .sync_flag (sync_flag)
    );

    assert_sync_with_word_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sync_flag) |-> word_vld);
    assert_idle_no_word_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_vld |=> !word_vld);
endmodule

// File: tb/dsz_comma_deser_tb.sv
module dsz_comma_deser_tb;
    localparam int CLK_PERIOD = 10;
    localparam logic [9:0] COMMA = 10'b0011111010;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_main = 1'b0, ser_loop = 1'b0, loop_sel = 1'b0, bit_vld = 1'b0;
    logic frame_en = 1'b0, narrow = 1'b0;
    logic [19:0] par_data;
    logic word_vld, sync_flag;

    dsz_comma_deser u_dut (
        .clk(clk), .rst_n(rst_n), .ser_main(ser_main), .ser_loop(ser_loop),
        .loop_sel(loop_sel), .bit_vld(bit_vld), .frame_en(frame_en), .narrow(narrow),
        .par_data(par_data), .word_vld(word_vld), .sync_flag(sync_flag)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk = 0, n_bad = 0;
    logic bits [0:8191];
    int nb, m_start, wr, rd;
    logic [19:0] exp_data [0:1023];
    logic exp_sync [0:1023];
    logic [19:0] last_data;
    logic last_sync, prev_vld, mon_en = 1'b0;
    logic [15:0] lfsr = 16'hACE1;
    string cur_tag = "R1";

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic next_rnd(output logic b);
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        b = lfsr[0];
    endtask

    // Reference model: one accepted bit; deliver the bit ten places back.
    task automatic model_add(input logic b);
        int d, w;
        bit is_comma;
        logic [19:0] word;
        bits[nb] = b;
        nb++;
        if (nb > 10) begin
            d = nb - 11;
            w = narrow ? 10 : 20;
            is_comma = 1'b1;
            for (int k = 0; k < 10; k++)
                if (bits[d+k] !== COMMA[9-k]) is_comma = 1'b0;
            if (frame_en && is_comma) m_start = d;
            if (d - m_start + 1 == w) begin
                word = narrow ? 20'h003FF : 20'h0;
                for (int k = 0; k < w; k++) word[(narrow ? 10 : 0) + k] = bits[m_start+k];
                exp_data[wr] = word;
                is_comma = 1'b1;
                for (int k = 0; k < 10; k++)
                    if (bits[m_start+k] !== COMMA[9-k]) is_comma = 1'b0;
                exp_sync[wr] = is_comma;
                wr++;
                m_start = d + 1;
            end
        end
    endtask

    task automatic send_bit(input logic b);
        logic o;
        next_rnd(o);
        @(negedge clk);
        bit_vld = 1'b1;
        if (loop_sel) begin ser_loop = b; ser_main = o; end
        else          begin ser_main = b; ser_loop = o; end
        model_add(b);
    endtask

    task automatic idle(input int n);
        logic a, c;
        for (int i = 0; i < n; i++) begin
            next_rnd(a); next_rnd(c);
            @(negedge clk);
            bit_vld = 1'b0; ser_main = a; ser_loop = c;
        end
    endtask

    task automatic send_rand(input int n, input bit gaps);
        logic b, g;
        for (int i = 0; i < n; i++) begin
            if (gaps) begin next_rnd(g); if (g) idle(1); end
            next_rnd(b);
            send_bit(b);
        end
    endtask

    task automatic send_comma();
        for (int k = 9; k >= 0; k--) send_bit(COMMA[k]);
    endtask

    task automatic do_reset(input logic fr, input logic nw, input logic lp);
        @(negedge clk);
        mon_en = 1'b0; rst_n = 1'b0; bit_vld = 1'b0;
        frame_en = fr; narrow = nw; loop_sel = lp;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        nb = 0; m_start = 0; wr = 0; rd = 0;
        last_data = 20'hFFFFF; last_sync = 1'b0; prev_vld = 1'b0;
        check(par_data == 20'hFFFFF, "R1", "reset par_data", 32'(par_data), 32'hFFFFF);
        check(word_vld == 1'b0, "R1", "reset word_vld", 32'(word_vld), 0);
        check(sync_flag == 1'b0, "R1", "reset sync_flag", 32'(sync_flag), 0);
        mon_en = 1'b1;
    endtask

    task automatic finish_run();
        idle(4);
        check(rd == wr, cur_tag, "word count", 32'(rd), 32'(wr));
    endtask

    // Mode change between bits; model restarts on narrow rise or frame fall.
    task automatic set_mode(input logic fr, input logic nw);
        idle(2);
        @(negedge clk);
        if ((nw && !narrow) || (frame_en && !fr)) m_start = (nb >= 10) ? nb - 10 : 0;
        frame_en = fr; narrow = nw;
        idle(2);
    endtask

    // Output monitor: compares each word and checks holding between words.
    always @(negedge clk) begin
        if (mon_en && rst_n) begin
            if (word_vld) begin
                if (prev_vld) check(1'b0, "R11", "back-to-back word_vld", 1, 0);
                if (rd < wr) begin
                    check(par_data == exp_data[rd], cur_tag, "word data",
                          32'(par_data), 32'(exp_data[rd]));
                    check(sync_flag == exp_sync[rd], "R6", "sync flag",
                          32'(sync_flag), 32'(exp_sync[rd]));
                end else begin
                    check(1'b0, cur_tag, "unexpected word", 32'(par_data), 0);
                end
                rd++;
                last_data = par_data;
                last_sync = sync_flag;
            end else begin
                check(par_data == last_data && sync_flag == last_sync, "R11 R10",
                      "hold between words", 32'({sync_flag, par_data}),
                      32'({last_sync, last_data}));
            end
            prev_vld = word_vld;
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        n_bad++;
        $display("FAIL R11 watchdog expired actual=%0d expected=%0d", n_chk, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        // R5 R6 R3: comma swept over every offset of a wide word, framed.
        for (int off = 0; off < 20; off++) begin
            cur_tag = "R5 R3";
            do_reset(1'b1, 1'b0, 1'b0);
            send_rand(off, 1'b0); send_comma(); send_rand(43, 1'b0);
            send_comma(); send_rand(37, 1'b0);
            finish_run();
        end
        // R5 R6 R4: same sweep in narrow mode.
        for (int off = 0; off < 10; off++) begin
            cur_tag = "R5 R4";
            do_reset(1'b1, 1'b1, 1'b0);
            send_rand(off, 1'b0); send_comma(); send_rand(23, 1'b0);
            send_comma(); send_rand(31, 1'b0);
            finish_run();
        end
        // R7 R3: unframed wide, commas ignored for alignment.
        for (int off = 0; off < 20; off += 3) begin
            cur_tag = "R7 R3";
            do_reset(1'b0, 1'b0, 1'b0);
            send_rand(off, 1'b0); send_comma(); send_rand(50, 1'b0);
            finish_run();
        end
        // R7 R4: unframed narrow.
        for (int off = 0; off < 10; off += 2) begin
            cur_tag = "R7 R4";
            do_reset(1'b0, 1'b1, 1'b0);
            send_rand(off, 1'b0); send_comma(); send_rand(33, 1'b0);
            finish_run();
        end
        // R2 R10 R5: loopback input, gapped strobe, framed, both widths.
        for (int nw = 0; nw < 2; nw++) begin
            cur_tag = "R2 R10 R5";
            do_reset(1'b1, nw[0], 1'b1);
            send_rand(7, 1'b1); send_comma(); send_rand(60, 1'b1);
            send_comma(); send_rand(45, 1'b1);
            finish_run();
        end
        // R8: framing dropped mid-stream restarts the counter.
        cur_tag = "R8";
        do_reset(1'b1, 1'b0, 1'b0);
        send_rand(13, 1'b0); send_comma(); send_rand(27, 1'b0);
        set_mode(1'b0, 1'b0);
        send_rand(7, 1'b0); send_comma(); send_rand(50, 1'b0);
        finish_run();
        // R9: switch to narrow mid-stream restarts the counter.
        cur_tag = "R9";
        do_reset(1'b0, 1'b0, 1'b0);
        send_rand(33, 1'b0);
        set_mode(1'b0, 1'b1);
        send_rand(47, 1'b0);
        finish_run();

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule